// File: doc/BRIEF.md
# Banked Cache-Control Register File

This block is the system-control register bank of a processor core that has separate instruction and data caches and a protection unit built from address regions. The core reaches it through one access port. The port carries a 4-bit register number, a write strobe and a 32-bit write word. Two side inputs go with every access. A side bit chooses between the data-side copy and the instruction-side copy of any register that exists twice. A 3-bit region index chooses one of the eight region descriptors on each side.

Read data is combinational. It reflects the contents selected by the current register number, side bit and region index. A write takes effect at the rising clock edge. Register 7 is a write-only command register. A write to it causes a single-cycle command pulse in the following cycle. The pulse carries a 3-bit maintenance operation code and a word-aligned address, and the cache and write-buffer logic downstream consumes it. This block does not model the caches themselves.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, every writable register reads zero. This covers all 16 region descriptors and their enable bits (bit 0).
- R2: Register 0 is read-only. It returns parameter ID_VALUE when side_sel is 0 and CFG_VALUE when side_sel is 1. Writes to it have no effect.
- R3: Registers 1, 3 and 15 each hold one full 32-bit word. side_sel has no effect on them.
- R4: Registers 2, 5 and 9 each have two independent 32-bit copies. side_sel=0 reads and writes the data copy, and side_sel=1 reads and writes the instruction copy.
- R5: Register 6 holds sixteen independent descriptors. Each one is addressed by {side_sel, region_idx}.
- R6: A descriptor keeps the base address in bits [31:12], the size in bits [5:1] and the enable flag in bit 0. Bits [11:6] are dropped on write and read as zero.
- R7: A write to register 7 raises cmd_valid for exactly the next cycle. cmd_op is then {side_sel, wdata[1], wdata[0]}, with these meanings: 0 flush the whole data cache, 1 flush one data line, 2 clean one data line, 3 clean and flush one data line, 4 flush the whole instruction cache, 5 flush one instruction line, 6 prefetch one instruction line, 7 drain the write buffer.
- R8: With the pulse, cmd_addr equals the written word with bits [1:0] cleared. For example, 0x80000002 gives 0x80000000.
- R9: Register 7 reads zero. A read of any register, and any cycle that is not a write to register 7, leaves cmd_valid low in the next cycle.
- R10: Register numbers 4, 8 and 10 to 14 read zero. Writes to them change no register.
- R11: State changes only in a cycle where both acc_en and acc_wr are high. The new value is visible on rdata from the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| reg_num | input | 4 | Register number |
| side_sel | input | 1 | 0 = data copy, 1 = instruction copy |
| region_idx | input | 3 | Region descriptor index for register 6 |
| wdata | input | 32 | Write word |
| rdata | output | 32 | Read word for the current selection |
| cmd_valid | output | 1 | One-cycle maintenance command pulse |
| cmd_op | output | 3 | Maintenance operation code |
| cmd_addr | output | 32 | Word-aligned command address |

## Verification
The bench builds the block with the default eight regions. It gives ID_VALUE and CFG_VALUE two unrelated patterns, so a swapped or stuck side bit on register 0 shows at once. With eight regions and two sides, every descriptor slot can be written with a distinct value and read back. Any aliasing between sides or indices then shows up as a mismatch. Random traffic covers all sixteen register numbers and back-to-back command writes, and each read and each pulse is compared against a behavioural model on every cycle.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned RNUM_W = 4;

  localparam logic [RNUM_W-1:0] RN_IDENT  = 4'd0;
  localparam logic [RNUM_W-1:0] RN_CTRL   = 4'd1;
  localparam logic [RNUM_W-1:0] RN_CACHEN = 4'd2;
  localparam logic [RNUM_W-1:0] RN_BUFF   = 4'd3;
  localparam logic [RNUM_W-1:0] RN_PERM   = 4'd5;
  localparam logic [RNUM_W-1:0] RN_REGION = 4'd6;
  localparam logic [RNUM_W-1:0] RN_MAINT  = 4'd7;
  localparam logic [RNUM_W-1:0] RN_LOCK   = 4'd9;
  localparam logic [RNUM_W-1:0] RN_TEST   = 4'd15;

  typedef enum logic [2:0] {
    OP_D_FLUSH_ALL   = 3'd0,
    OP_D_FLUSH_LINE  = 3'd1,
    OP_D_CLEAN_LINE  = 3'd2,
    OP_D_CLEAN_FLUSH = 3'd3,
    OP_I_FLUSH_ALL   = 3'd4,
    OP_I_FLUSH_LINE  = 3'd5,
    OP_I_PREFETCH    = 3'd6,
    OP_WB_DRAIN      = 3'd7
  } maint_op_e;

  localparam int unsigned BASE_LSB = 12;
  localparam int unsigned SIZE_MSB = 5;

  // Keeps base [31:12], size [5:1] and enable [0]
  function automatic logic [WORD_W-1:0] region_pack(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] keep;
    keep = '0;
    for (int b = 0; b < WORD_W; b++)
      keep[b] = (b >= BASE_LSB) || (b <= SIZE_MSB);
    return w & keep;
  endfunction

  function automatic maint_op_e maint_op_of(input logic side, input logic [1:0] lo);
    return maint_op_e'({side, lo});
  endfunction

  function automatic logic [WORD_W-1:0] line_addr(input logic [WORD_W-1:0] w);
    return {w[WORD_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/sysctl_bank_pair.sv
`timescale 1ns/1ps
module sysctl_bank_pair #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         side,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rd_q
);
  logic [W-1:0] copy_q [2];

  for (genvar s = 0; s < 2; s++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        copy_q[s] <= '0;
      else if (wr_en && (side == s[0]))
        copy_q[s] <= wdata;
    end
  end

  assign rd_q = copy_q[side];
endmodule

// File: rtl/sysctl_region_file.sv
`timescale 1ns/1ps
module sysctl_region_file
  import sysctl_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              side,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_entry
);
  logic [WORD_W-1:0] ent_q [2][NUM_REGIONS];
  logic [WORD_W-1:0] packed_w;

  assign packed_w = region_pack(wdata);

  for (genvar s = 0; s < 2; s++) begin : g_side
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ent_q[s][r] <= '0;
        else if (wr_en && (side == s[0]) && (idx == r[IDX_W-1:0]))
          ent_q[s][r] <= packed_w;
      end
    end
  end

  always_comb begin
    rd_entry = '0;
    for (int r = 0; r < NUM_REGIONS; r++)
      if (idx == r[IDX_W-1:0]) rd_entry = ent_q[side][r];
  end
endmodule

// File: rtl/sysctl_maint_cmd.sv
`timescale 1ns/1ps
module sysctl_maint_cmd
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              side,
  input  logic [WORD_W-1:0] wdata,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [WORD_W-1:0] cmd_addr
);
  maint_op_e op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      op_q      <= OP_D_FLUSH_ALL;
      cmd_addr  <= '0;
    end else begin
      cmd_valid <= fire;
      if (fire) begin
        op_q     <= maint_op_of(side, wdata[1:0]);
        cmd_addr <= line_addr(wdata);
      end
    end
  end

  assign cmd_op = op_q;
endmodule

// File: rtl/sysctl_regbank.sv
`timescale 1ns/1ps
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_VALUE    = 32'h5A10_0001,
  parameter logic [31:0] CFG_VALUE   = 32'h0000_2424,
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [3:0]       reg_num,
  input  logic             side_sel,
  input  logic [IDX_W-1:0] region_idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [31:0]      cmd_addr
);
  // Named internal events
  logic wr_hit;
  logic wr_ctrl, wr_buff, wr_test;
  logic wr_cachen, wr_perm, wr_lock;
  logic wr_region, maint_fire;

  assign wr_hit = acc_en && acc_wr;

  always_comb begin
    wr_ctrl    = 1'b0;
    wr_buff    = 1'b0;
    wr_test    = 1'b0;
    wr_cachen  = 1'b0;
    wr_perm    = 1'b0;
    wr_lock    = 1'b0;
    wr_region  = 1'b0;
    maint_fire = 1'b0;
    if (wr_hit) begin
      case (reg_num)
        RN_CTRL:   wr_ctrl    = 1'b1;
        RN_BUFF:   wr_buff    = 1'b1;
        RN_TEST:   wr_test    = 1'b1;
        RN_CACHEN: wr_cachen  = 1'b1;
        RN_PERM:   wr_perm    = 1'b1;
        RN_LOCK:   wr_lock    = 1'b1;
        RN_REGION: wr_region  = 1'b1;
        RN_MAINT:  maint_fire = 1'b1;
        default:   ;
      endcase
    end
  end

  // Unbanked words
  logic [31:0] ctrl_q, buff_q, test_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      buff_q <= '0;
      test_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_buff) buff_q <= wdata;
      if (wr_test) test_q <= wdata;
    end
  end

  // Banked words: cache enable, permission, lockdown
  localparam int unsigned NUM_PAIRS = 3;
  logic [NUM_PAIRS-1:0] pair_wr;
  logic [31:0]          pair_rd [NUM_PAIRS];

  assign pair_wr = {wr_lock, wr_perm, wr_cachen};

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    sysctl_bank_pair #(.W(WORD_W)) u_pair (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (pair_wr[p]),
      .side  (side_sel),
      .wdata (wdata),
      .rd_q  (pair_rd[p])
    );
  end

  logic [31:0] region_rd;

  sysctl_region_file #(.NUM_REGIONS(NUM_REGIONS)) u_regions (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_region),
    .side     (side_sel),
    .idx      (region_idx),
    .wdata    (wdata),
    .rd_entry (region_rd)
  );

  sysctl_maint_cmd u_maint (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (maint_fire),
    .side      (side_sel),
    .wdata     (wdata),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr)
  );

  always_comb begin
    case (reg_num)
      RN_IDENT:  rdata = side_sel ? CFG_VALUE : ID_VALUE;
      RN_CTRL:   rdata = ctrl_q;
      RN_BUFF:   rdata = buff_q;
      RN_TEST:   rdata = test_q;
      RN_CACHEN: rdata = pair_rd[0];
      RN_PERM:   rdata = pair_rd[1];
      RN_LOCK:   rdata = pair_rd[2];
      RN_REGION: rdata = region_rd;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/sysctl_regbank_chk.sv
`timescale 1ns/1ps
module sysctl_regbank_chk #(
  parameter logic [31:0] ID_VALUE  = 32'h0,
  parameter logic [31:0] CFG_VALUE = 32'h0,
  parameter int unsigned IDX_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_en,
  input logic             acc_wr,
  input logic [3:0]       reg_num,
  input logic             side_sel,
  input logic [IDX_W-1:0] region_idx,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [31:0]      cmd_addr
);
  logic maint_wr;
  logic unimpl;
  assign maint_wr = acc_en && acc_wr && (reg_num == 4'd7);
  assign unimpl   = (reg_num == 4'd4) || (reg_num == 4'd8) ||
                    ((reg_num >= 4'd10) && (reg_num <= 4'd14));

  // R7
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maint_wr |=> cmd_valid);

  // R9
  no_spurious_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !maint_wr |=> !cmd_valid);

  // R7
  cmd_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maint_wr |=> (cmd_op == $past({side_sel, wdata[1:0]})));

  // R8
  cmd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maint_wr |=> (cmd_addr[31:2] == $past(wdata[31:2]) && cmd_addr[1:0] == 2'b00));

  // R9
  maint_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_num == 4'd7) |-> (rdata == 32'h0));

  // R6
  region_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_num == 4'd6) |-> (rdata[11:6] == 6'h0));

  // R2
  ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_num == 4'd0) |-> (rdata == (side_sel ? CFG_VALUE : ID_VALUE)));

  // R10
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl |-> (rdata == 32'h0));
endmodule

bind sysctl_regbank sysctl_regbank_chk #(
  .ID_VALUE(ID_VALUE), .CFG_VALUE(CFG_VALUE), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
  .reg_num(reg_num), .side_sel(side_sel), .region_idx(region_idx),
  .wdata(wdata), .rdata(rdata), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_addr(cmd_addr)
);

// File: tb/sysctl_regbank_test.sv
`timescale 1ns/1ps
module sysctl_regbank_test;
  localparam logic [31:0] T_ID  = 32'hC0DE_1234;
  localparam logic [31:0] T_CFG = 32'h0F0F_2233;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0, side_sel = 1'b0;
  logic [3:0]  reg_num = '0;
  logic [2:0]  region_idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, cmd_addr;
  logic        cmd_valid;
  logic [2:0]  cmd_op;

  always #10 clk = ~clk;

  sysctl_regbank #(.ID_VALUE(T_ID), .CFG_VALUE(T_CFG), .NUM_REGIONS(8)) uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .reg_num(reg_num), .side_sel(side_sel), .region_idx(region_idx),
    .wdata(wdata), .rdata(rdata), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  // Behavioural reference model
  int unsigned m_single [16];
  int unsigned m_bank   [16][2];
  int unsigned m_reg    [2][8];
  bit          exp_v;
  int unsigned exp_op, exp_addr;

  int tests = 0, fails = 0;
  string phase = "";

  function automatic int unsigned model_read(int rn, int sd, int ix);
    if (rn == 0) return sd ? T_CFG : T_ID;
    if (rn == 1 || rn == 3 || rn == 15) return m_single[rn];
    if (rn == 2 || rn == 5 || rn == 9) return m_bank[rn][sd];
    if (rn == 6) return m_reg[sd][ix];
    return 0;
  endfunction

  function automatic string tag_of(int rn);
    if (phase != "") return phase;
    if (rn == 0) return "R2";
    if (rn == 1 || rn == 3 || rn == 15) return "R3";
    if (rn == 2 || rn == 5 || rn == 9) return "R4";
    if (rn == 6) return "R5 R6";
    if (rn == 7) return "R9";
    return "R10";
  endfunction

  task automatic check(string req, int unsigned act, int unsigned exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare, then update the model past the edge
  task automatic step(bit en, bit wr, int rn, bit sd, int ix, int unsigned wd);
    acc_en = en; acc_wr = wr; reg_num = rn[3:0]; side_sel = sd;
    region_idx = ix[2:0]; wdata = wd;
    #1;
    check(tag_of(rn), rdata, model_read(rn, sd, ix));
    check("R7 R9 valid", {31'b0, cmd_valid}, {31'b0, exp_v});
    if (exp_v) begin
      check("R7 op", {29'b0, cmd_op}, exp_op);
      check("R8 addr", cmd_addr, exp_addr);
    end
    @(posedge clk);
    exp_v = 0;
    if (en && wr) begin
      if (rn == 1 || rn == 3 || rn == 15) m_single[rn] = wd;
      else if (rn == 2 || rn == 5 || rn == 9) m_bank[rn][sd] = wd;
      else if (rn == 6) m_reg[sd][ix] = wd & 32'hFFFF_F03F;
      else if (rn == 7) begin
        exp_v = 1;
        exp_op = sd * 4 + wd % 4;
        exp_addr = wd - wd % 4;
      end
    end
    @(negedge clk);
  endtask

  task automatic sweep_reads();
    for (int rn = 0; rn < 16; rn++)
      for (int sd = 0; sd < 2; sd++)
        step(1, 0, rn, sd[0], 0, 32'hFFFF_FFFF);
    for (int sd = 0; sd < 2; sd++)
      for (int ix = 0; ix < 8; ix++)
        step(1, 0, 6, sd[0], ix, 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    foreach (m_single[i]) m_single[i] = 0;
    foreach (m_bank[i, j]) m_bank[i][j] = 0;
    foreach (m_reg[i, j]) m_reg[i][j] = 0;
    exp_v = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: everything clear after reset
    phase = "R1";
    sweep_reads();
    phase = "";

    // R2: writes to identification register have no effect
    step(1, 1, 0, 0, 0, 32'h1111_1111);
    step(1, 1, 0, 1, 0, 32'h2222_2222);
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0);

    // R3: unbanked registers, side bit irrelevant
    step(1, 1, 1, 0, 0, 32'hA5A5_0001);
    step(1, 1, 3, 1, 0, 32'h0000_BEEF);
    step(1, 1, 15, 0, 5, 32'hFFFF_FFFF);
    step(1, 0, 1, 1, 0, 0);
    step(1, 0, 3, 0, 0, 0);
    step(1, 0, 15, 1, 0, 0);

    // R4: banked copies are independent
    for (int rn = 2; rn <= 9; rn++)
      if (rn == 2 || rn == 5 || rn == 9) begin
        step(1, 1, rn, 0, 0, 32'hD000_0000 + rn);
        step(1, 1, rn, 1, 0, 32'h1000_0000 + rn);
        step(1, 0, rn, 0, 0, 0);
        step(1, 0, rn, 1, 0, 0);
      end

    // R5 R6: all sixteen descriptors, all bits driven
    for (int sd = 0; sd < 2; sd++)
      for (int ix = 0; ix < 8; ix++)
        step(1, 1, 6, sd[0], ix, 32'hFFFF_FFC0 | (sd * 8 + ix) | 32'h0000_0FC0);
    for (int sd = 0; sd < 2; sd++)
      for (int ix = 0; ix < 8; ix++)
        step(1, 0, 6, sd[0], ix, 0);

    // R7 R8: every operation code, including the prefetch example
    for (int op = 0; op < 8; op++)
      step(1, 1, 7, op[2], 0, 32'h8000_0000 | (op * 32'h100) | (op % 4));
    step(1, 1, 7, 1, 0, 32'h8000_0002);
    step(1, 0, 7, 1, 0, 32'hFFFF_FFFF);   // R9: read of 7, no pulse
    step(0, 1, 7, 0, 0, 32'h0000_0003);   // R11: no strobe, no pulse
    step(1, 0, 0, 0, 0, 0);

    // R10: writes to unused numbers change nothing
    for (int rn = 4; rn < 15; rn++)
      if (rn == 4 || rn == 8 || rn >= 10)
        step(1, 1, rn, rn % 2, rn % 8, 32'hDEAD_0000 + rn);
    phase = "R10";
    sweep_reads();

    // R11: disabled or read accesses do not write
    phase = "R11";
    step(0, 1, 1, 0, 0, 32'h5555_5555);
    step(1, 0, 3, 0, 0, 32'h5555_5555);
    step(0, 1, 6, 1, 2, 32'h5555_5555);
    step(1, 0, 1, 0, 0, 0);
    step(1, 0, 3, 0, 0, 0);
    step(1, 0, 6, 1, 2, 0);
    phase = "";

    // Random traffic, compared every cycle
    for (int k = 0; k < 3000; k++)
      step($urandom % 4 != 0, $urandom % 2 == 1, $urandom % 16,
           $urandom % 2 == 1, $urandom % 8, $urandom);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule